// File: doc/BRIEF.md
# Memory Protection Rights Checker

This block decides whether one memory access may go ahead once the protection segment table has been searched. It takes the attribute word of the matching segment, the privilege ring of the requester, the kind of access (load, store or instruction fetch) and a flag from the table search that reports an ambiguous lookup with more than one matching segment. From these it works out the read, write and execute rights that the segment grants, and the cache policy for the access: write-back, write-through or bypass. It then reports either a pass or a fault with a cause code.

On a pass the physical address is the virtual address unchanged, and the block also reports the region granularity, which is the configured segment alignment. The block does not raise exceptions. A pipeline stage next to it turns the cause code into a trap. Every request arrives with a valid strobe, and its result appears on registered outputs one clock later.

Top module: `mpr_checker`

## Requirements
- R1: The block samples a request on a rising edge where `req_valid` is 1 and presents its result after that edge, with `rsp_valid` high for exactly that one cycle. On edges without a request, every result output keeps its value. The port `req_attr` carries attribute bits [20:8]: bits [11:8] hold the rights code and bits [20:12] hold the memory type. Attribute bits below bit 8 have no effect.
- R2: In ring 0 (`req_ring` equal to 0), the rights code grants the following. Codes 0–3 grant nothing. Codes 4 and 12 grant R. Codes 5 and 13 grant RX. Codes 6, 9, 10 and 14 grant RW. Codes 7, 11 and 15 grant RWX. Code 8 grants W alone.
- R3: In any nonzero ring, the rights code grants the following. Codes 0–7 grant nothing. Code 8 grants W. Codes 10 and 12 grant R. Codes 11 and 13 grant RX. Code 14 grants RW. Codes 9 and 15 grant RWX.
- R4: `req_kind` encodes the access: 0 is a load and needs R, 1 is a store and needs W, 2 or 3 is a fetch and needs X. When the needed right is missing, the cause is `CAUSE_LD_DENY`, `CAUSE_ST_DENY` or `CAUSE_IF_DENY` according to the kind.
- R5: The memory type is cacheable when (type & 0x18F) == 0x089, when (type & 0x188) == 0x080, or when (type & 0x180) == 0x180. `rsp_policy` is 2 (write-back) for a cacheable type whose bit 4 is set, 1 (write-through) for a cacheable type whose bit 4 is clear, and 0 (bypass) for any other type.
- R6: When `req_multi` is 1, the result is a fault whatever the rights are. The cause is `CAUSE_DATA_MULTI` for a load or store and `CAUSE_INST_MULTI` for a fetch. The rights and policy outputs still show the decode of `req_attr`.
- R7: On a pass, `rsp_fault` is 0, `rsp_cause` is 0, `rsp_paddr` equals the request's `req_vaddr` and `rsp_granule` equals `ALIGN`. On a fault, `rsp_fault` is 1 and both `rsp_paddr` and `rsp_granule` are 0.
- R8: While `rst` is high at a rising edge, every output is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_attr | input | 13 | Segment attribute bits [20:8] |
| req_ring | input | RING_W | Privilege ring, 0 is most privileged |
| req_kind | input | 2 | 0 load, 1 store, 2/3 fetch |
| req_multi | input | 1 | Table search found more than one segment |
| req_vaddr | input | ADDR_W | Virtual address |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_read | output | 1 | Read granted |
| rsp_write | output | 1 | Write granted |
| rsp_exec | output | 1 | Execute granted |
| rsp_policy | output | 2 | 0 bypass, 1 write-through, 2 write-back |
| rsp_fault | output | 1 | Result is a fault |
| rsp_cause | output | CAUSE_W | Fault cause, 0 on pass |
| rsp_paddr | output | ADDR_W | Physical address on pass |
| rsp_granule | output | ADDR_W | Region granularity on pass |

## Verification
The bench builds the block with a 2-bit ring, a 32-bit address, an alignment of 0x1000 and five distinct cause values. This lets it reach rings 1, 2 and 3 and confirm that every nonzero ring shares one table, and it tells every cause code apart. The bench runs every rights code against every ring and access kind. It runs all 512 memory types, and it runs the all-zero and all-one address extremes. Multi-hit requests are sent with segments that grant all rights and with segments that grant none, so the priority of the multi-hit check is shown in both cases.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int RIGHTS_LSB = 8;
  localparam int TYPE_LSB   = 12;
  localparam int TYPE_W     = 9;
  localparam int ATTR_MSB   = TYPE_LSB + TYPE_W - 1;
  localparam int N_CACHE_PAT = 3;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    POL_BYPASS = 2'd0,
    POL_WT     = 2'd1,
    POL_WB     = 2'd2
  } policy_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } rights_t;

  localparam logic [N_CACHE_PAT-1:0][TYPE_W-1:0] CACHE_PAT_MASK =
    {9'h180, 9'h188, 9'h18F};
  localparam logic [N_CACHE_PAT-1:0][TYPE_W-1:0] CACHE_PAT_VAL =
    {9'h180, 9'h080, 9'h089};
endpackage

// File: rtl/mpr_rights_decode.sv
module mpr_rights_decode
  import mpr_pkg::*;
(
  input  logic [3:0] code,
  input  logic       ring_nz,
  output rights_t    rights
);
  rights_t priv_r;
  rights_t user_r;

  always_comb begin
    case (code)
      4'd4, 4'd12:               priv_r = '{r: 1'b1, w: 1'b0, x: 1'b0};
      4'd5, 4'd13:               priv_r = '{r: 1'b1, w: 1'b0, x: 1'b1};
      4'd6, 4'd9, 4'd10, 4'd14:  priv_r = '{r: 1'b1, w: 1'b1, x: 1'b0};
      4'd7, 4'd11, 4'd15:        priv_r = '{r: 1'b1, w: 1'b1, x: 1'b1};
      4'd8:                      priv_r = '{r: 1'b0, w: 1'b1, x: 1'b0};
      default:                   priv_r = '{r: 1'b0, w: 1'b0, x: 1'b0};
    endcase
  end

  always_comb begin
    case (code)
      4'd8:                      user_r = '{r: 1'b0, w: 1'b1, x: 1'b0};
      4'd10, 4'd12:              user_r = '{r: 1'b1, w: 1'b0, x: 1'b0};
      4'd11, 4'd13:              user_r = '{r: 1'b1, w: 1'b0, x: 1'b1};
      4'd14:                     user_r = '{r: 1'b1, w: 1'b1, x: 1'b0};
      4'd9, 4'd15:               user_r = '{r: 1'b1, w: 1'b1, x: 1'b1};
      default:                   user_r = '{r: 1'b0, w: 1'b0, x: 1'b0};
    endcase
  end

  assign rights = ring_nz ? user_r : priv_r;
endmodule

// File: rtl/mpr_cache_class.sv
module mpr_cache_class
  import mpr_pkg::*;
(
  input  logic [TYPE_W-1:0] mem_type,
  output policy_e           policy
);
  logic [N_CACHE_PAT-1:0] pat_hit;

  for (genvar i = 0; i < N_CACHE_PAT; i++) begin : g_pat
    assign pat_hit[i] = (mem_type & CACHE_PAT_MASK[i]) == CACHE_PAT_VAL[i];
  end

  always_comb begin
    if (|pat_hit) policy = mem_type[4] ? POL_WB : POL_WT;
    else          policy = POL_BYPASS;
  end
endmodule

// File: rtl/mpr_checker.sv
module mpr_checker
  import mpr_pkg::*;
#(
  parameter int              ADDR_W           = 32,
  parameter int              RING_W           = 2,
  parameter int              CAUSE_W          = 8,
  parameter logic [ADDR_W-1:0] ALIGN          = 32'h0000_1000,
  parameter logic [CAUSE_W-1:0] CAUSE_LD_DENY    = 8'd12,
  parameter logic [CAUSE_W-1:0] CAUSE_ST_DENY    = 8'd13,
  parameter logic [CAUSE_W-1:0] CAUSE_IF_DENY    = 8'd14,
  parameter logic [CAUSE_W-1:0] CAUSE_DATA_MULTI = 8'd9,
  parameter logic [CAUSE_W-1:0] CAUSE_INST_MULTI = 8'd8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic [ATTR_MSB:RIGHTS_LSB] req_attr,
  input  logic [RING_W-1:0]          req_ring,
  input  logic [1:0]                 req_kind,
  input  logic                       req_multi,
  input  logic [ADDR_W-1:0]          req_vaddr,
  output logic                       rsp_valid,
  output logic                       rsp_read,
  output logic                       rsp_write,
  output logic                       rsp_exec,
  output logic [1:0]                 rsp_policy,
  output logic                       rsp_fault,
  output logic [CAUSE_W-1:0]         rsp_cause,
  output logic [ADDR_W-1:0]          rsp_paddr,
  output logic [ADDR_W-1:0]          rsp_granule
);
  rights_t              granted;
  policy_e              pol;
  logic                 is_fetch;
  logic                 is_store;
  logic                 needed_ok;
  logic                 fault_d;
  logic [CAUSE_W-1:0]   cause_d;

  mpr_rights_decode u_rights (
    .code    (req_attr[RIGHTS_LSB+3:RIGHTS_LSB]),
    .ring_nz (|req_ring),
    .rights  (granted)
  );

  mpr_cache_class u_cache (
    .mem_type (req_attr[ATTR_MSB:TYPE_LSB]),
    .policy   (pol)
  );

  assign is_fetch = req_kind[1];
  assign is_store = (req_kind == KIND_STORE);

  always_comb begin
    if (is_fetch)      needed_ok = granted.x;
    else if (is_store) needed_ok = granted.w;
    else               needed_ok = granted.r;
  end

  always_comb begin
    fault_d = 1'b1;
    if (req_multi)       cause_d = is_fetch ? CAUSE_INST_MULTI : CAUSE_DATA_MULTI;
    else if (!needed_ok) cause_d = is_fetch ? CAUSE_IF_DENY :
                                   (is_store ? CAUSE_ST_DENY : CAUSE_LD_DENY);
    else begin
      fault_d = 1'b0;
      cause_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_read    <= 1'b0;
      rsp_write   <= 1'b0;
      rsp_exec    <= 1'b0;
      rsp_policy  <= 2'd0;
      rsp_fault   <= 1'b0;
      rsp_cause   <= '0;
      rsp_paddr   <= '0;
      rsp_granule <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_read    <= granted.r;
        rsp_write   <= granted.w;
        rsp_exec    <= granted.x;
        rsp_policy  <= pol;
        rsp_fault   <= fault_d;
        rsp_cause   <= cause_d;
        rsp_paddr   <= fault_d ? '0 : req_vaddr;
        rsp_granule <= fault_d ? '0 : ALIGN;
      end
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R1
  AST_RING0_LOW_CODES: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ring == '0 && req_attr[RIGHTS_LSB+3:RIGHTS_LSB+2] == 2'b00
    |=> !rsp_read && !rsp_write && !rsp_exec); // R2
  AST_RINGNZ_LOW_CODES: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ring != '0 && !req_attr[RIGHTS_LSB+3]
    |=> !rsp_read && !rsp_write && !rsp_exec); // R3
  AST_LOAD_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_multi && req_kind == 2'd0 |=> rsp_fault == !rsp_read); // R4
  AST_STORE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_multi && req_kind == 2'd1 |=> rsp_fault == !rsp_write); // R4
  AST_POLICY_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rsp_policy != 2'd3); // R5
  AST_MULTI_WINS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_multi |=> rsp_fault &&
      (rsp_cause == CAUSE_DATA_MULTI || rsp_cause == CAUSE_INST_MULTI)); // R6
  AST_PASS_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_fault ||
      (rsp_paddr == $past(req_vaddr) && rsp_granule == ALIGN && rsp_cause == '0)); // R7
endmodule

// File: tb/mpr_checker_tb.sv
module mpr_checker_tb;
  localparam int ADDR_W  = 32;
  localparam int RING_W  = 2;
  localparam int CAUSE_W = 8;
  localparam logic [31:0] ALIGN = 32'h0000_1000;
  localparam logic [7:0] C_LD = 8'd12, C_ST = 8'd13, C_IF = 8'd14,
                         C_DM = 8'd9,  C_IM = 8'd8;
  localparam int PW = 1 + CAUSE_W + 3 + 2 + 2*ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [20:8] req_attr = '0;
  logic [RING_W-1:0] req_ring = '0;
  logic [1:0] req_kind = '0;
  logic req_multi = 1'b0;
  logic [ADDR_W-1:0] req_vaddr = '0;
  logic rsp_valid, rsp_read, rsp_write, rsp_exec, rsp_fault;
  logic [1:0] rsp_policy;
  logic [CAUSE_W-1:0] rsp_cause;
  logic [ADDR_W-1:0] rsp_paddr, rsp_granule;

  always #4 clk = ~clk;

  mpr_checker #(
    .ADDR_W(ADDR_W), .RING_W(RING_W), .CAUSE_W(CAUSE_W), .ALIGN(ALIGN),
    .CAUSE_LD_DENY(C_LD), .CAUSE_ST_DENY(C_ST), .CAUSE_IF_DENY(C_IF),
    .CAUSE_DATA_MULTI(C_DM), .CAUSE_INST_MULTI(C_IM)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_attr(req_attr),
    .req_ring(req_ring), .req_kind(req_kind), .req_multi(req_multi),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_read(rsp_read),
    .rsp_write(rsp_write), .rsp_exec(rsp_exec), .rsp_policy(rsp_policy),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
    .rsp_granule(rsp_granule)
  );

  typedef struct {
    logic [PW-1:0] val;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  logic [PW-1:0] last_exp = '0;

  function automatic logic [PW-1:0] observed();
    return {rsp_fault, rsp_cause, rsp_read, rsp_write, rsp_exec, rsp_policy,
            rsp_paddr, rsp_granule};
  endfunction

  function automatic logic [2:0] ref_rights(int ring, int code);
    if (ring == 0) begin
      case (code)
        4, 12: return 3'b100;
        5, 13: return 3'b101;
        6, 9, 10, 14: return 3'b110;
        7, 11, 15: return 3'b111;
        8: return 3'b010;
        default: return 3'b000;
      endcase
    end else begin
      case (code)
        8: return 3'b010;
        9, 15: return 3'b111;
        10, 12: return 3'b100;
        11, 13: return 3'b101;
        14: return 3'b110;
        default: return 3'b000;
      endcase
    end
  endfunction

  function automatic logic [1:0] ref_policy(logic [8:0] mt);
    logic cach;
    cach = ((mt & 9'h18F) == 9'h089) || ((mt & 9'h188) == 9'h080) ||
           ((mt & 9'h180) == 9'h180);
    if (!cach) return 2'd0;
    return mt[4] ? 2'd2 : 2'd1;
  endfunction

  task automatic check(input logic [PW-1:0] act, input logic [PW-1:0] exp,
                       input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [20:8] attr, input int ring, input int kind,
                      input logic multi, input logic [31:0] va, input string tag);
    logic [2:0] rt;
    logic ok, flt;
    logic [7:0] cause;
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_attr = attr; req_ring = ring[RING_W-1:0];
    req_kind = kind[1:0]; req_multi = multi; req_vaddr = va;
    rt = ref_rights(ring, int'(attr[11:8]));
    ok = (kind >= 2) ? rt[0] : (kind == 1) ? rt[1] : rt[2];
    flt = multi || !ok;
    if (multi)    cause = (kind >= 2) ? C_IM : C_DM;
    else if (!ok) cause = (kind >= 2) ? C_IF : (kind == 1) ? C_ST : C_LD;
    else          cause = 8'd0;
    e.val = {flt, cause, rt, ref_policy(attr[20:12]),
             flt ? 32'd0 : va, flt ? 32'd0 : ALIGN};
    e.tag = tag;
    last_exp = e.val;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (rsp_valid) begin
        if (q.size() == 0) check(observed(), '1, "R1 unexpected result");
        else begin
          exp_t e;
          e = q.pop_front();
          check(observed(), e.val, e.tag);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({rsp_valid, observed()}, '0, "R8 reset state");
    rst = 1'b0;

    // R2 / R3 / R4: every code, every ring, every kind
    for (int ring = 0; ring < 4; ring++)
      for (int code = 0; code < 16; code++)
        for (int kind = 0; kind < 4; kind++)
          send({9'h000, code[3:0]}, ring, kind, 1'b0,
               32'hA000_0000 + (ring << 12) + (code << 4) + kind,
               kind != 0 ? "R4 denial cause" : (ring == 0 ? "R2 ring0 rights" : "R3 ring nz rights"));

    // R5: all memory types
    for (int mt = 0; mt < 512; mt++)
      send({mt[8:0], 4'hF}, 0, 0, 1'b0, 32'h1234_0000 + mt, "R5 cache policy");

    // R1: rights field position (code in [11:8], type in [20:12])
    send({9'h1FF, 4'h0}, 0, 0, 1'b0, 32'h0000_0040, "R1 field code0");
    send({9'h000, 4'h4}, 0, 0, 1'b0, 32'h0000_0044, "R1 field code4");

    // R6: multi-hit wins over rights
    send({9'h089, 4'hF}, 0, 0, 1'b1, 32'h5000_0000, "R6 multi load");
    send({9'h089, 4'hF}, 0, 1, 1'b1, 32'h5000_0004, "R6 multi store");
    send({9'h089, 4'hF}, 0, 2, 1'b1, 32'h5000_0008, "R6 multi fetch");
    send({9'h000, 4'h0}, 3, 3, 1'b1, 32'h5000_000C, "R6 multi fetch no rights");

    // R7: address extremes on pass
    send({9'h180, 4'hF}, 0, 0, 1'b0, 32'h0000_0000, "R7 pass zero addr");
    send({9'h180, 4'hF}, 2, 1, 1'b0, 32'hFFFF_FFFF, "R7 pass top addr");
    send({9'h000, 4'h9}, 1, 2, 1'b0, 32'h8000_0001, "R7 pass fetch");

    @(negedge clk);
    req_valid = 1'b0;
    req_attr = '0; req_vaddr = 32'hDEAD_0000; req_multi = 1'b1;
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
    #1;
    check({rsp_valid, observed()}, {1'b0, last_exp}, "R1 hold when idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule